// File: doc/BRIEF.md
# Return-from-Trap State Restore Unit

This block resolves what happens when a return-from-trap instruction executes. It looks at the current supervisor (S), previous-supervisor (PS) and trap-enable (ET) status bits, the core's debug-mode flag and the debug-select field of the instruction. From these it picks one outcome, in a fixed priority order. The outcome can be a halt request, a quiet skip while a privilege fault is raised elsewhere, an illegal-instruction request, a restore from the normal saved-PC register, a restore from the debug saved-PC register, or a plain skip.

The chosen outcome is held in a small state register. Every response appears on the clock edge that samples `insn_vld`. All request outputs are single-cycle pulses. The next PC and the status word are registered values. The status word keeps its last written value until the next restore writes it.

The outcome states are these:
- `RT_IDLE`: no instruction.
- `RT_HALT`: S clear and ET clear.
- `RT_PRIV_SKIP`: S clear and ET set.
- `RT_ILLEGAL`: S set and ET set.
- `RT_RESTORE_NORM`: normal restore.
- `RT_RESTORE_DBG`: debug restore.
- `RT_NOOP`: the mode and the debug field do not match.

Every state moves to the class of the current input when `insn_vld` is high, and to `RT_IDLE` otherwise.

Top module: `rett_restore_unit`

## Requirements
- R1: After reset the design drives the following values: `pc_vld`, `halt_req`, `illegal_req`, `stat_we` and `dbg_clr` are low, `next_pc` is 0 and `stat_o` is 0.
- R2: A valid instruction sampled at a clock edge produces exactly one `pc_vld` pulse from that edge onward. With `insn_vld` low, no strobe or request is raised at the next edge.
- R3: If S=0 and ET=0, the unit pulses `halt_req` and sets `next_pc` to PC+4. It does not write the status word.
- R4: If S=0 and ET=1, the unit sets `next_pc` to PC+4 and raises no request, no status write and no debug clear. S=0 takes priority over every other condition.
- R5: If S=1 and ET=1, the unit pulses `illegal_req` and sets `next_pc` to PC+4. It does not write the status word.
- R6: If S=1, ET=0, debug mode is off and the debug field is 0, the unit does the following:
  - sets `next_pc` to the normal saved PC;
  - pulses `stat_we`;
  - writes a status word with ET=1, S equal to the incoming PS, and PS unchanged.
- R7: If S=1, ET=0, debug mode is on and the debug field is 1, the unit does the following:
  - sets `next_pc` to the debug saved PC;
  - pulses `stat_we` and `dbg_clr`;
  - writes a status word with ET and S taken from the saved debug bits, and PS unchanged.
- R8: If S=1, ET=0 and the debug field does not match the debug mode, the unit sets `next_pc` to PC+4 and raises no request or write.
- R9: `stat_o` packs the status bits as bit 2 = S, bit 1 = PS and bit 0 = ET. It keeps its last written value through every cycle without `stat_we`.
- R10: PC+4 wraps modulo 2^ADDR_W, so PC 0xFFFFFFFC advances to 0.
- R11: `dbg_clr` is raised only together with `stat_we`. At most one of `halt_req`, `illegal_req` and `stat_we` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_vld | input | 1 | Return-from-trap instruction executes this cycle |
| cur_pc | input | ADDR_W | PC of the instruction |
| cur_s | input | 1 | Current supervisor bit |
| cur_ps | input | 1 | Current previous-supervisor bit |
| cur_et | input | 1 | Current trap-enable bit |
| dbg_mode | input | 1 | Core is in debug mode |
| dbg_sel | input | 1 | Debug-select field of the instruction |
| norm_save_pc | input | ADDR_W | Saved PC for a normal return |
| dbg_save_pc | input | ADDR_W | Saved PC for a debug return |
| dbg_save_s | input | 1 | Saved supervisor bit for a debug return |
| dbg_save_et | input | 1 | Saved trap-enable bit for a debug return |
| pc_vld | output | 1 | `next_pc` was updated this cycle |
| next_pc | output | ADDR_W | Next program counter |
| stat_o | output | 3 | Status word {S, PS, ET} |
| stat_we | output | 1 | Status write strobe |
| dbg_clr | output | 1 | Leave-debug-mode strobe |
| halt_req | output | 1 | Halt request pulse |
| illegal_req | output | 1 | Illegal-instruction request pulse |

## Verification
Every result of this unit is due exactly one clock edge after `insn_vld` is sampled:
- the PC;
- the status word;
- the request and strobe pulses.

The bench drives its inputs at the falling edge. It first compares the outputs against the expectation formed from the inputs it drove half a period before the preceding rising edge, and then forms a new expectation from the new inputs. An expected pulse is therefore checked in the one cycle where it is due. The next comparison confirms that the pulse has dropped again, unless a back-to-back instruction calls for it once more.

// File: rtl/rett_pkg.sv
package rett_pkg;

    // Outcome classes, one per resolution path of a return-from-trap
    typedef enum logic [2:0] {
        RT_IDLE         = 3'd0,
        RT_HALT         = 3'd1,
        RT_PRIV_SKIP    = 3'd2,
        RT_ILLEGAL      = 3'd3,
        RT_RESTORE_NORM = 3'd4,
        RT_RESTORE_DBG  = 3'd5,
        RT_NOOP         = 3'd6
    } rett_state_e;

    // Status word layout: bit 2 = S, bit 1 = PS, bit 0 = ET
    typedef struct packed {
        logic s;
        logic ps;
        logic et;
    } rett_stat_t;

endpackage

// File: rtl/rett_classify.sv
module rett_classify
    import rett_pkg::*;
(
    input  logic        vld,
    input  logic        s,
    input  logic        et,
    input  logic        dbg_mode,
    input  logic        dbg_sel,
    output rett_state_e kind
);

    // Priority: supervisor check, then trap-enable, then normal, then debug
    always_comb begin
        if (!vld)
            kind = RT_IDLE;
        else if (!s)
            kind = et ? RT_PRIV_SKIP : RT_HALT;
        else if (et)
            kind = RT_ILLEGAL;
        else if (!dbg_mode && !dbg_sel)
            kind = RT_RESTORE_NORM;
        else if (dbg_mode && dbg_sel)
            kind = RT_RESTORE_DBG;
        else
            kind = RT_NOOP;
    end

endmodule

// File: rtl/rett_target.sv
module rett_target
    import rett_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int PC_STEP = 4
) (
    input  rett_state_e       kind,
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic [ADDR_W-1:0] norm_save_pc,
    input  logic [ADDR_W-1:0] dbg_save_pc,
    input  logic              cur_ps,
    input  logic              dbg_save_s,
    input  logic              dbg_save_et,
    output logic [ADDR_W-1:0] pc_nxt,
    output rett_stat_t        stat_nxt
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(PC_STEP);

    logic [ADDR_W-1:0] pc_adv;
    assign pc_adv = cur_pc + STEP;

    always_comb begin
        pc_nxt   = pc_adv;
        stat_nxt = '{s: 1'b0, ps: cur_ps, et: 1'b0};
        unique case (kind)
            RT_RESTORE_NORM: begin
                pc_nxt   = norm_save_pc;
                stat_nxt = '{s: cur_ps, ps: cur_ps, et: 1'b1};
            end
            RT_RESTORE_DBG: begin
                pc_nxt   = dbg_save_pc;
                stat_nxt = '{s: dbg_save_s, ps: cur_ps, et: dbg_save_et};
            end
            RT_IDLE, RT_HALT, RT_PRIV_SKIP, RT_ILLEGAL, RT_NOOP: begin
                pc_nxt = pc_adv;
            end
            default: begin
                pc_nxt = pc_adv;
            end
        endcase
    end

endmodule

// File: rtl/rett_restore_unit.sv
module rett_restore_unit
    import rett_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int PC_STEP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_vld,
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic              cur_s,
    input  logic              cur_ps,
    input  logic              cur_et,
    input  logic              dbg_mode,
    input  logic              dbg_sel,
    input  logic [ADDR_W-1:0] norm_save_pc,
    input  logic [ADDR_W-1:0] dbg_save_pc,
    input  logic              dbg_save_s,
    input  logic              dbg_save_et,
    output logic              pc_vld,
    output logic [ADDR_W-1:0] next_pc,
    output logic [2:0]        stat_o,
    output logic              stat_we,
    output logic              dbg_clr,
    output logic              halt_req,
    output logic              illegal_req
);

    rett_state_e       state_d, state_q;
    logic [ADDR_W-1:0] pc_d, pc_q;
    rett_stat_t        stat_d, stat_q;
    logic              writes_stat;

    rett_classify u_classify (
        .vld      (insn_vld),
        .s        (cur_s),
        .et       (cur_et),
        .dbg_mode (dbg_mode),
        .dbg_sel  (dbg_sel),
        .kind     (state_d)
    );

    rett_target #(
        .ADDR_W  (ADDR_W),
        .PC_STEP (PC_STEP)
    ) u_target (
        .kind         (state_d),
        .cur_pc       (cur_pc),
        .norm_save_pc (norm_save_pc),
        .dbg_save_pc  (dbg_save_pc),
        .cur_ps       (cur_ps),
        .dbg_save_s   (dbg_save_s),
        .dbg_save_et  (dbg_save_et),
        .pc_nxt       (pc_d),
        .stat_nxt     (stat_d)
    );

    assign writes_stat = (state_d == RT_RESTORE_NORM) || (state_d == RT_RESTORE_DBG);

    // State register and registered results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RT_IDLE;
            pc_q    <= '0;
            stat_q  <= '0;
        end else begin
            state_q <= state_d;
            if (insn_vld)
                pc_q <= pc_d;
            if (writes_stat)
                stat_q <= stat_d;
        end
    end

    // Output decode from the state
    always_comb begin
        pc_vld      = 1'b1;
        stat_we     = 1'b0;
        dbg_clr     = 1'b0;
        halt_req    = 1'b0;
        illegal_req = 1'b0;
        unique case (state_q)
            RT_IDLE:         pc_vld = 1'b0;
            RT_HALT:         halt_req = 1'b1;
            RT_PRIV_SKIP:    ;
            RT_ILLEGAL:      illegal_req = 1'b1;
            RT_RESTORE_NORM: stat_we = 1'b1;
            RT_RESTORE_DBG: begin
                stat_we = 1'b1;
                dbg_clr = 1'b1;
            end
            RT_NOOP:         ;
            default:         pc_vld = 1'b0;
        endcase
    end

    assign next_pc = pc_q;
    assign stat_o  = stat_q;

endmodule

// File: rtl/rett_restore_sva.sv
module rett_restore_sva #(
    parameter int ADDR_W  = 32,
    parameter int PC_STEP = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              insn_vld,
    input logic [ADDR_W-1:0] cur_pc,
    input logic              cur_s,
    input logic              cur_ps,
    input logic              cur_et,
    input logic              dbg_mode,
    input logic              dbg_sel,
    input logic [ADDR_W-1:0] norm_save_pc,
    input logic [ADDR_W-1:0] dbg_save_pc,
    input logic              dbg_save_s,
    input logic              dbg_save_et,
    input logic              pc_vld,
    input logic [ADDR_W-1:0] next_pc,
    input logic [2:0]        stat_o,
    input logic              stat_we,
    input logic              dbg_clr,
    input logic              halt_req,
    input logic              illegal_req
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(PC_STEP);

    p_vld_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        insn_vld |=> pc_vld);

    p_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_vld |=> !(pc_vld || stat_we || dbg_clr || halt_req || illegal_req));

    p_halt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_vld && !cur_s && !cur_et) |=>
            (halt_req && !stat_we && next_pc == $past(cur_pc) + STEP));

    p_priv_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_vld && !cur_s && cur_et) |=>
            (!halt_req && !illegal_req && !stat_we && !dbg_clr));

    p_illegal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_vld && cur_s && cur_et) |=>
            (illegal_req && next_pc == $past(cur_pc) + STEP));

    p_norm_restore_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_vld && cur_s && !cur_et && !dbg_mode && !dbg_sel) |=>
            (stat_we && !dbg_clr && next_pc == $past(norm_save_pc)
             && stat_o == {$past(cur_ps), $past(cur_ps), 1'b1}));

    p_dbg_restore_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_vld && cur_s && !cur_et && dbg_mode && dbg_sel) |=>
            (stat_we && dbg_clr && next_pc == $past(dbg_save_pc)
             && stat_o == {$past(dbg_save_s), $past(cur_ps), $past(dbg_save_et)}));

    p_mismatch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_vld && cur_s && !cur_et && (dbg_mode != dbg_sel)) |=>
            (!stat_we && !halt_req && !illegal_req && next_pc == $past(cur_pc) + STEP));

    p_stat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_we |-> $stable(stat_o));

    p_clr_with_we_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_clr |-> stat_we);

    p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({halt_req, illegal_req, stat_we}));

endmodule

bind rett_restore_unit rett_restore_sva #(
    .ADDR_W  (ADDR_W),
    .PC_STEP (PC_STEP)
) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .insn_vld     (insn_vld),
    .cur_pc       (cur_pc),
    .cur_s        (cur_s),
    .cur_ps       (cur_ps),
    .cur_et       (cur_et),
    .dbg_mode     (dbg_mode),
    .dbg_sel      (dbg_sel),
    .norm_save_pc (norm_save_pc),
    .dbg_save_pc  (dbg_save_pc),
    .dbg_save_s   (dbg_save_s),
    .dbg_save_et  (dbg_save_et),
    .pc_vld       (pc_vld),
    .next_pc      (next_pc),
    .stat_o       (stat_o),
    .stat_we      (stat_we),
    .dbg_clr      (dbg_clr),
    .halt_req     (halt_req),
    .illegal_req  (illegal_req)
);

// File: tb/rett_restore_unit_tb_top.sv
module rett_restore_unit_tb_top;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          insn_vld = 1'b0;
    logic [AW-1:0] cur_pc = '0;
    logic          cur_s = 1'b0, cur_ps = 1'b0, cur_et = 1'b0;
    logic          dbg_mode = 1'b0, dbg_sel = 1'b0;
    logic [AW-1:0] norm_save_pc = '0, dbg_save_pc = '0;
    logic          dbg_save_s = 1'b0, dbg_save_et = 1'b0;
    logic          pc_vld, stat_we, dbg_clr, halt_req, illegal_req;
    logic [AW-1:0] next_pc;
    logic [2:0]    stat_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Reference expectation
    logic          e_vld = 0, e_we = 0, e_clr = 0, e_halt = 0, e_ill = 0;
    logic [AW-1:0] e_pc = '0;
    logic [2:0]    e_stat = '0;
    string         e_tag = "R1";

    always #10 clk = ~clk;

    rett_restore_unit #(.ADDR_W(AW), .PC_STEP(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .insn_vld(insn_vld), .cur_pc(cur_pc),
        .cur_s(cur_s), .cur_ps(cur_ps), .cur_et(cur_et),
        .dbg_mode(dbg_mode), .dbg_sel(dbg_sel),
        .norm_save_pc(norm_save_pc), .dbg_save_pc(dbg_save_pc),
        .dbg_save_s(dbg_save_s), .dbg_save_et(dbg_save_et),
        .pc_vld(pc_vld), .next_pc(next_pc), .stat_o(stat_o),
        .stat_we(stat_we), .dbg_clr(dbg_clr),
        .halt_req(halt_req), .illegal_req(illegal_req)
    );

    task automatic chk(string tag, logic [AW-1:0] act, logic [AW-1:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(e_tag, AW'(pc_vld), AW'(e_vld), "pc_vld");
        chk(e_tag, next_pc, e_pc, "next_pc");
        chk((e_we ? e_tag : "R9"), AW'(stat_o), AW'(e_stat), "stat_o");
        chk(e_tag, AW'(stat_we), AW'(e_we), "stat_we");
        chk((e_clr ? e_tag : "R11"), AW'(dbg_clr), AW'(e_clr), "dbg_clr");
        chk(e_tag, AW'(halt_req), AW'(e_halt), "halt_req");
        chk(e_tag, AW'(illegal_req), AW'(e_ill), "illegal_req");
    endtask

    // Behavioural model of the outcome of the inputs just driven
    task automatic model();
        e_we = 0; e_clr = 0; e_halt = 0; e_ill = 0;
        e_vld = insn_vld;
        if (!insn_vld) begin
            e_tag = "R2";
            return;
        end
        if (!cur_s && !cur_et) begin
            e_tag = "R3"; e_halt = 1; e_pc = cur_pc + 4;
        end else if (!cur_s) begin
            e_tag = "R4"; e_pc = cur_pc + 4;
        end else if (cur_et) begin
            e_tag = "R5"; e_ill = 1; e_pc = cur_pc + 4;
        end else if (!dbg_mode && !dbg_sel) begin
            e_tag = "R6"; e_we = 1; e_pc = norm_save_pc;
            e_stat = {cur_ps, cur_ps, 1'b1};
        end else if (dbg_mode && dbg_sel) begin
            e_tag = "R7"; e_we = 1; e_clr = 1; e_pc = dbg_save_pc;
            e_stat = {dbg_save_s, cur_ps, dbg_save_et};
        end else begin
            e_tag = "R8"; e_pc = cur_pc + 4;
        end
        if (cur_pc == 32'hFFFF_FFFC && e_pc == 0) e_tag = "R10";
    endtask

    task automatic step(logic v, logic [AW-1:0] pc, logic s, logic ps, logic et,
                        logic dm, logic ds, logic [AW-1:0] npc, logic [AW-1:0] dpc,
                        logic bs, logic bet);
        @(negedge clk);
        compare_all();
        insn_vld = v; cur_pc = pc; cur_s = s; cur_ps = ps; cur_et = et;
        dbg_mode = dm; dbg_sel = ds; norm_save_pc = npc; dbg_save_pc = dpc;
        dbg_save_s = bs; dbg_save_et = bet;
        model();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        e_tag = "R1";
        compare_all();
        rst_n = 1'b1;
        step(0, 32'h100, 1, 1, 0, 0, 0, 32'h4000, 32'h8000, 1, 1);      // R2 idle
        step(1, 32'h100, 0, 0, 0, 0, 0, 32'h4000, 32'h8000, 1, 1);      // R3 halt
        step(1, 32'h200, 0, 1, 1, 1, 1, 32'h4000, 32'h8000, 1, 1);      // R4 priority
        step(1, 32'h300, 1, 0, 1, 0, 0, 32'h4000, 32'h8000, 1, 1);      // R5 illegal
        step(1, 32'h400, 1, 0, 0, 0, 0, 32'h4440, 32'h8000, 1, 1);      // R6 PS=0
        step(1, 32'h404, 1, 1, 0, 0, 0, 32'h5550, 32'h8000, 0, 0);      // R6 PS=1
        step(0, 32'h0,   0, 0, 0, 0, 0, 32'h0,    32'h0,    0, 0);      // R9 hold
        step(1, 32'h500, 1, 0, 0, 1, 1, 32'h4000, 32'h8880, 1, 0);      // R7
        step(1, 32'h504, 1, 1, 0, 1, 1, 32'h4000, 32'h9990, 0, 1);      // R7 back-to-back
        step(1, 32'h600, 1, 1, 0, 1, 0, 32'h4000, 32'h8000, 1, 1);      // R8
        step(1, 32'h604, 1, 1, 0, 0, 1, 32'h4000, 32'h8000, 1, 1);      // R8
        step(1, 32'hFFFF_FFFC, 1, 0, 0, 1, 0, 32'h4000, 32'h8000, 1, 1); // R10 wrap
        step(1, 32'hFFFF_FFFC, 0, 0, 1, 0, 0, 32'h4000, 32'h8000, 1, 1); // R10 wrap
        step(0, 32'h0,   0, 0, 0, 0, 0, 32'h0,    32'h0,    0, 0);
        for (int i = 0; i < 400; i++) begin
            step(1'($urandom_range(0, 3) != 0), $urandom & 32'hFFFF_FFFC,
                 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                 $urandom & 32'hFFFF_FFFC, $urandom & 32'hFFFF_FFFC,
                 1'($urandom), 1'($urandom));
        end
        step(0, 32'h0, 0, 0, 0, 0, 0, 32'h0, 32'h0, 0, 0);
        @(negedge clk);
        compare_all();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule